// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block sits between a simple host request port and an asynchronous 256K x 8 DRAM whose row and column addresses share nine pins. Each host request carries an 18-bit word address, a read/write flag and a write byte. The controller splits the address into a row (upper nine bits) and a column (lower nine bits). It presents the row and then strobes the row select low. Next it presents the column, sets the write or read direction, and strobes the column select low. It finishes by returning a one-cycle completion pulse together with the read byte.

After an access the row stays open, so a following access to the same row needs only a column cycle. An access to a different row first releases the row select for a precharge interval and then opens the new row. A free-running timer requests refresh at a fixed period. Refresh opens one row without any column strobe and then precharges. A nine-bit counter walks through all 512 rows in turn. A pending refresh is served before the next host request. The timing of row access, column access and precharge is set by parameters in clock cycles.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, all four strobes (ras_n, cas_n, we_n, oe_n) are high and req_done is low.
- R2: A host access that opens a row drives addr[17:9] on the pins when ras_n falls, and ras_n stays low for at least T_ROW cycles before cas_n falls.
- R3: Every column strobe drives addr[8:0] on the pins when cas_n falls, holds the pins stable while cas_n is low, requires ras_n low, and keeps cas_n low for exactly T_COL cycles.
- R4: On a write (req_write=1), we_n is low at least one cycle before cas_n falls, oe_n stays high, and the data pins carry req_wdata while cas_n falls.
- R5: On a read (req_write=0), oe_n is low at least one cycle before cas_n falls, we_n stays high, the controller leaves the data pins undriven, and req_rdata carries the byte from the pins when req_done pulses.
- R6: we_n and oe_n are never low in the same cycle.
- R7: Consecutive accesses to the already open row cause no new falling edge of ras_n.
- R8: Before every falling edge of ras_n, ras_n has been high for at least T_PRE cycles.
- R9: Each refresh is a falling edge of ras_n with no falling edge of cas_n before ras_n rises again. Refresh rows follow the order 0, 1, 2, ... 511 and then wrap to 0.
- R10: Refresh number n (counting from 1) begins within a bounded number of cycles after cycle n*REF_INTERVAL since reset, even while host requests are held back-to-back.
- R11: A read returns the byte most recently written to the same 18-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row in [17:9], column in [8:0] |
| req_wdata | input | 8 | Write byte |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read byte, valid with req_done |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq | inout | 8 | Bidirectional data bus |

## Verification
A row-major write sweep over edge rows and columns (0, 1, mid-range, 511) mostly produces open-row hits, with one row change per new row. A column-major read-back of the same cells forces a row miss and a precharge on every access, so the two sweeps separate the hit path from the miss path while both check data integrity. A same-row burst started right after a refresh counts row openings to show that a hit opens no row. A long idle stretch then runs more than 512 refreshes, which checks the row order, the wrap to zero and the refresh timing window against the back-to-back host traffic seen earlier.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_DONE,
        ST_PRE
    } seq_state_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int INTERVAL = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == TW'(INTERVAL - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int COL_W  = 9,
    parameter int DATA_W = 8,
    parameter int T_ROW  = 2,
    parameter int T_COL  = 2,
    parameter int T_PRE  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_tick,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_done,
    output logic [DATA_W-1:0]        req_rdata,
    output logic                     ras_n,
    output logic                     cas_n,
    output logic                     we_n,
    output logic                     oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mux_addr,
    input  logic [DATA_W-1:0]        dq_in,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe
);
    localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_MAX = (T_ROW > T_COL) ? ((T_ROW > T_PRE) ? T_ROW : T_PRE)
                                           : ((T_COL > T_PRE) ? T_COL : T_PRE);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              row_open;
        logic [ROW_W-1:0]  open_row;
        logic              ref_pend;
        logic              ref_mode;
        logic [ROW_W-1:0]  ref_row;
        logic              tgt_wr;
        logic [ROW_W-1:0]  tgt_row;
        logic [COL_W-1:0]  tgt_col;
        logic [DATA_W-1:0] tgt_wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    assign in_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    always_comb begin
        r_d = r_q;
        if (ref_tick) r_d.ref_pend = 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.ref_pend) begin
                    r_d.cnt = '0;
                    if (r_q.row_open) begin
                        r_d.st       = ST_PRE;
                        r_d.row_open = 1'b0;
                    end else begin
                        r_d.st       = ST_ROW;
                        r_d.ref_mode = 1'b1;
                        r_d.ref_pend = ref_tick;
                    end
                end else if (req_valid) begin
                    r_d.tgt_wr    = req_write;
                    r_d.tgt_row   = in_row;
                    r_d.tgt_col   = in_col;
                    r_d.tgt_wdata = req_wdata;
                    r_d.cnt       = '0;
                    if (r_q.row_open && (r_q.open_row == in_row)) begin
                        r_d.st = ST_COL;
                    end else if (r_q.row_open) begin
                        r_d.st       = ST_PRE;
                        r_d.row_open = 1'b0;
                    end else begin
                        r_d.st       = ST_ROW;
                        r_d.ref_mode = 1'b0;
                        r_d.row_open = 1'b1;
                        r_d.open_row = in_row;
                    end
                end
            end
            ST_ROW: begin
                if (r_q.cnt == CNT_W'(T_ROW - 1)) begin
                    r_d.cnt = '0;
                    if (r_q.ref_mode) begin
                        r_d.st       = ST_PRE;
                        r_d.ref_mode = 1'b0;
                        r_d.ref_row  = r_q.ref_row + 1'b1;
                    end else begin
                        r_d.st = ST_COL;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_COL: begin
                if (r_q.cnt == CNT_W'(T_COL)) begin
                    r_d.st = ST_DONE;
                    if (!r_q.tgt_wr) r_d.rdata = dq_in;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            ST_PRE: begin
                if (r_q.cnt == CNT_W'(T_PRE - 1)) r_d.st = ST_IDLE;
                else                               r_d.cnt = r_q.cnt + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    // Moore decode of the pin strobes from the registered state
    always_comb begin
        ras_n    = !((r_q.st == ST_ROW) ||
                     (r_q.row_open && (r_q.st inside {ST_IDLE, ST_COL, ST_DONE})));
        cas_n    = !((r_q.st == ST_COL) && (r_q.cnt != '0));
        we_n     = !((r_q.st == ST_COL) && r_q.tgt_wr);
        oe_n     = !((r_q.st == ST_COL) && !r_q.tgt_wr);
        dq_oe    = (r_q.st == ST_COL) && r_q.tgt_wr;
        dq_out   = r_q.tgt_wdata;
        req_done = (r_q.st == ST_DONE);
        req_rdata = r_q.rdata;
        if (r_q.st == ST_ROW)
            mux_addr = r_q.ref_mode ? MUX_W'(r_q.ref_row) : MUX_W'(r_q.tgt_row);
        else
            mux_addr = MUX_W'(r_q.tgt_col);
    end

    // Run-length counters used only by the timing properties below
    logic [7:0] ras_lo_run_q, ras_hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_run_q <= '0;
            ras_hi_run_q <= 8'hFF;
        end else begin
            ras_lo_run_q <= ras_n ? 8'h00 : ((ras_lo_run_q == 8'hFF) ? ras_lo_run_q : ras_lo_run_q + 1'b1);
            ras_hi_run_q <= !ras_n ? 8'h00 : ((ras_hi_run_q == 8'hFF) ? ras_hi_run_q : ras_hi_run_q + 1'b1);
        end
    end

    a_r6_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(mux_addr));

    a_r2_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (ras_lo_run_q >= 8'(T_ROW)));

    a_r8_precharge_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_run_q >= 8'(T_PRE)));

    a_r4_we_early: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));

    a_r5_oe_early: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !oe_n) |-> $past(!oe_n));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
    parameter int ROW_W        = 9,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int T_ROW        = 2,
    parameter int T_COL        = 2,
    parameter int T_PRE        = 2,
    parameter int REF_INTERVAL = 100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_done,
    output logic [DATA_W-1:0]      req_rdata,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    inout  wire  [DATA_W-1:0]      dram_dq
);
    logic              ref_tick;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;

    dram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    dram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_done (req_done),
        .req_rdata(req_rdata),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n),
        .oe_n     (dram_oe_n),
        .mux_addr (dram_addr),
        .dq_in    (dram_dq),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    assign dram_dq = dq_oe ? dq_out : {DATA_W{1'bz}};
endmodule

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
    localparam int T_ROW = 2, T_COL = 2, T_PRE = 2, REF_INT = 100;
    localparam int LAT_MAX = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_done;
    logic [7:0]  req_rdata;
    logic        ras_n, cas_n, we_n, oe_n;
    logic [8:0]  maddr;
    wire  [7:0]  dq;

    always #10 clk = ~clk;

    dram_ctrl #(.T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE), .REF_INTERVAL(REF_INT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .req_rdata(req_rdata), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(maddr), .dram_dq(dq)
    );

    int n_chk = 0, n_bad = 0;
    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Behavioural memory model
    logic [7:0] mem [int];
    logic [8:0] m_row, m_col;
    logic [7:0] rd_byte = 8'h00;
    always @(negedge ras_n) m_row = maddr;
    always @(negedge cas_n) begin
        m_col = maddr;
        if (!we_n) mem[int'({m_row, m_col})] = dq;
        else rd_byte = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 8'h00;
    end
    assign dq = (!cas_n && !oe_n) ? rd_byte : 8'bz;

    // Expected values of the access in flight
    logic [8:0] exp_row = '0, exp_col = '0;
    logic [7:0] exp_wd = '0;

    // Pin monitor
    int cyc = 0, lo_run = 0, hi_run = 1000, cas_run = 0;
    int ref_n = 0, ras_falls = 0, fall_cyc = 0;
    logic p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1, had_cas = 0;
    logic [8:0] lat_row = '0;
    always @(negedge clk) if (rst_n) begin
        cyc++;
        if (p_ras && !ras_n) begin
            check("R8 precharge high run", int'(hi_run >= T_PRE), 1);
            lat_row = maddr; had_cas = 0; fall_cyc = cyc; ras_falls++;
        end
        if (p_cas && !cas_n) begin
            had_cas = 1;
            check("R2 row low run before CAS", int'(lo_run >= T_ROW), 1);
            check("R2 row address", lat_row, exp_row);
            check("R3 column address", maddr, exp_col);
            check("R6 WE and OE exclusive", int'(!we_n && !oe_n), 0);
            if (!we_n) begin
                check("R4 WE early", int'(!p_we), 1);
                check("R4 OE high on write", oe_n, 1);
                check("R4 write data", dq, exp_wd);
            end else begin
                check("R5 OE early", int'(!p_oe), 1);
            end
        end
        if (!p_cas && cas_n) check("R3 CAS low length", cas_run, T_COL);
        if (!p_ras && ras_n && !had_cas) begin
            check("R9 refresh row order", lat_row, ref_n % 512);
            check("R10 refresh start window",
                  int'(fall_cyc >= (ref_n + 1) * REF_INT && fall_cyc <= (ref_n + 1) * REF_INT + LAT_MAX), 1);
            if (ref_n == 512) check("R9 refresh wrap to row 0", lat_row, 0);
            ref_n++;
        end
        lo_run  = ras_n ? 0 : lo_run + 1;
        hi_run  = ras_n ? hi_run + 1 : 0;
        cas_run = cas_n ? 0 : cas_run + 1;
        p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n;
    end

    task automatic access(input logic wr, input logic [8:0] row, input logic [8:0] col,
                          input logic [7:0] wd, output logic [7:0] rd);
        exp_row = row; exp_col = col; exp_wd = wd;
        req_valid = 1; req_write = wr; req_addr = {row, col}; req_wdata = wd;
        do @(negedge clk); while (!req_done);
        rd = req_rdata;
        req_valid = 0;
    endtask

    function automatic logic [7:0] pat(input int row, input int col, input int salt);
        return 8'((row * 13 + col * 7 + salt) & 8'hFF);
    endfunction

    int rows [5] = '{0, 1, 255, 256, 511};
    int cols [4] = '{0, 1, 170, 511};

    initial begin
        logic [7:0] rd;
        int base, start;
        repeat (3) @(negedge clk);
        check("R1 ras_n in reset", ras_n, 1);
        check("R1 cas_n in reset", cas_n, 1);
        check("R1 we_n/oe_n in reset", int'({we_n, oe_n}), 3);
        check("R1 done low in reset", req_done, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 strobes high after reset", int'({ras_n, cas_n, we_n, oe_n}), 4'hF);

        // Row-major writes: hits inside a row, one miss per row change
        foreach (rows[i]) foreach (cols[j])
            access(1, 9'(rows[i]), 9'(cols[j]), pat(rows[i], cols[j], 60), rd);
        // Column-major reads: every access misses, exercises precharge (R8)
        foreach (cols[j]) foreach (rows[i]) begin
            access(0, 9'(rows[i]), 9'(cols[j]), 8'h00, rd);
            check("R11 R5 read-back after sweep", rd, pat(rows[i], cols[j], 60));
        end
        // Overwrite keeps the last byte
        access(1, 9'd511, 9'd511, 8'hA5, rd);
        access(1, 9'd511, 9'd511, 8'h5A, rd);
        access(0, 9'd511, 9'd511, 8'h00, rd);
        check("R11 last write wins", rd, 8'h5A);

        // Same-row burst just after a refresh: one row opening only (R7)
        start = ref_n;
        while (ref_n == start) @(negedge clk);
        base = ras_falls;
        for (int c = 0; c < 8; c++) access(1, 9'd300, 9'(c), pat(300, c, 9), rd);
        check("R7 single row opening for burst", ras_falls - base, 1);
        for (int c = 0; c < 8; c++) begin
            access(0, 9'd300, 9'(c), 8'h00, rd);
            check("R11 burst read-back", rd, pat(300, c, 9));
        end

        // Idle long enough to walk every refresh row and wrap (R9)
        while (ref_n < 514) @(negedge clk);
        check("R9 refresh count reached wrap", int'(ref_n >= 514), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog expired act=0 exp=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule